// File: doc/BRIEF.md
# Message RAM Parity Error Recorder

This block sits beside the parity checker of a message-object RAM access path. Each RAM access is framed by a start strobe and an end strobe. While an access is open, the checker reports one result per word it reads: a valid strobe, an error bit, the message object number and the word index within that object. The recorder folds every failing word of the access into one candidate error code. It keeps the highest failing word number and the message number that came with it. When the access closes, it commits that code to a held code register and raises a sticky parity-error flag.

Software sees two read-only words through a small read port. The status word carries the flag in bit 0, and reading it clears the flag. The code word carries the word number in bits 10:8 and the message number in bits 7:0. The held code survives soft resets and is cleared only by the power-on reset, so it stays available for diagnosis after the chip has been reset to recover.

Top module: `parity_err_recorder`

## Requirements
- R1: With `rd_sel`=1, `rd_data` shows the held word number in bits 10:8 and the held message number in bits 7:0, and bits 31:11 read 0.
- R2: With `rd_sel`=0, `rd_data` bit 0 is the parity-error flag and bits 31:1 read 0.
- R3: An access opens on `acc_start` and closes on `acc_end`, and both strobes may fall in the same cycle. If a check with `chk_valid`=1 and `chk_err`=1 occurs in any cycle from the opening cycle to the closing cycle, both included, the code and the flag update in the cycle after the closing cycle.
- R4: When several words of one access fail, the committed code holds the highest failing word number and the message number reported with it. On equal word numbers, the later check wins.
- R5: The flag stays set until a status read (`rd_en`=1, `rd_sel`=0). The read clears it from the next cycle on.
- R6: If a commit and a status read fall in the same cycle, the flag remains set.
- R7: A soft reset (`rst_n`=0) clears the flag and discards any open access, and leaves the held code unchanged.
- R8: A power-on reset (`por_n`=0) clears the flag, the open access and both code fields to 0.
- R9: A later access with an error overwrites the held code with its own values. An access without errors leaves the held code and the flag unchanged.
- R10: Checks outside an open access, and checks with `chk_err`=0, have no effect on the code or the flag.
- R11: Reading the code word (`rd_en`=1, `rd_sel`=1) does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous active-low power-on reset, clears everything |
| rst_n | input | 1 | Synchronous active-low soft reset, keeps the held code |
| acc_start | input | 1 | Opens a RAM access |
| acc_end | input | 1 | Closes the access and commits its merged error |
| chk_valid | input | 1 | A parity check result is present |
| chk_err | input | 1 | The checked word failed parity |
| chk_msg | input | 8 | Message object number of the checked word |
| chk_word | input | 3 | Word index of the checked word |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | 0 selects the status word, 1 selects the code word |
| rd_data | output | 32 | Read data, combinational from `rd_sel` |

## Verification
Every cycle, the checker confirms four things: the flag follows a commit, the flag holds until a status read, the status read clears it, and the held code never moves without a commit. It also checks that the unused bits of the code word stay zero. Only the bench scenarios show the rest, because it depends on the sequence across an access: which word and message win the merge, the collision of a commit with a status read, and the code surviving a soft reset while a power-on reset clears it.

// File: rtl/pe_pkg.sv
// Shared widths and read-word layout for the parity error recorder.
package pe_pkg;
    parameter int MSG_W      = 8;   // message number field width
    parameter int WORD_W     = 3;   // word number field width
    parameter int DATA_W     = 32;  // read port width
    parameter int FLAG_BIT   = 0;   // flag position in the status word
endpackage

// File: rtl/pe_merge.sv
// Access tracker and error merger.
// Opens an access on acc_start and closes it on acc_end. Folds the failing
// checks of the access into one candidate (highest word wins, later check on a
// tie) and presents a commit pulse with the candidate in the closing cycle.
// Assumes the word number is an unsigned index; the reset input is the
// combined soft and power-on reset.
module pe_merge #(
    parameter int MSG_W  = pe_pkg::MSG_W,
    parameter int WORD_W = pe_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_start,
    input  logic              acc_end,
    input  logic              chk_valid,
    input  logic              chk_err,
    input  logic [MSG_W-1:0]  chk_msg,
    input  logic [WORD_W-1:0] chk_word,
    output logic              commit,
    output logic [MSG_W-1:0]  commit_msg,
    output logic [WORD_W-1:0] commit_word
);
    logic              in_acc_q;
    logic              err_q;
    logic [MSG_W-1:0]  msg_q;
    logic [WORD_W-1:0] word_q;

    logic              active;
    logic              base_err;
    logic [MSG_W-1:0]  base_msg;
    logic [WORD_W-1:0] base_word;
    logic              hit;
    logic              take;
    logic              nxt_err;
    logic [MSG_W-1:0]  nxt_msg;
    logic [WORD_W-1:0] nxt_word;

    // Merge the current check into the candidate of the open access.
    always_comb begin
        active    = acc_start | in_acc_q;
        base_err  = acc_start ? 1'b0 : err_q;
        base_msg  = acc_start ? '0 : msg_q;
        base_word = acc_start ? '0 : word_q;
        hit       = active & chk_valid & chk_err;
        take      = hit & (!base_err || (chk_word >= base_word));
        nxt_err   = base_err | hit;
        nxt_msg   = take ? chk_msg  : base_msg;
        nxt_word  = take ? chk_word : base_word;
    end

    // Commit the merged candidate in the closing cycle, never during reset.
    always_comb begin
        commit      = rst_n & acc_end & active & nxt_err;
        commit_msg  = nxt_msg;
        commit_word = nxt_word;
    end

    // Hold the access state and the candidate between checks.
    always_ff @(posedge clk) begin
        if (!rst_n || acc_end) begin
            in_acc_q <= 1'b0;
            err_q    <= 1'b0;
            msg_q    <= '0;
            word_q   <= '0;
        end else begin
            in_acc_q <= active;
            err_q    <= nxt_err;
            msg_q    <= nxt_msg;
            word_q   <= nxt_word;
        end
    end
endmodule

// File: rtl/pe_code_reg.sv
// Held error code.
// Loads the committed message and word numbers. Only the power-on reset
// clears the code; soft resets are not connected here on purpose.
module pe_code_reg #(
    parameter int MSG_W  = pe_pkg::MSG_W,
    parameter int WORD_W = pe_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              load,
    input  logic [MSG_W-1:0]  msg_in,
    input  logic [WORD_W-1:0] word_in,
    output logic [MSG_W-1:0]  msg_q,
    output logic [WORD_W-1:0] word_q
);
    // Capture a committed code; clear only at power-on.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            msg_q  <= '0;
            word_q <= '0;
        end else if (load) begin
            msg_q  <= msg_in;
            word_q <= word_in;
        end
    end
endmodule

// File: rtl/pe_flag.sv
// Sticky parity error flag.
// Set by a commit and cleared by a status read. If both happen in one cycle,
// the set wins so that no error is lost.
module pe_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag_q
);
    // Sticky set, read-to-clear, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set)   flag_q <= 1'b1;
        else if (clr)   flag_q <= 1'b0;
    end
endmodule

// File: rtl/parity_err_recorder.sv
// Message RAM parity error recorder, top level.
// Ties the merger, the held code and the sticky flag together and exposes the
// status and code words on a combinational read port. Assumes the read and
// check inputs are synchronous to clk.
module parity_err_recorder #(
    parameter int MSG_W    = pe_pkg::MSG_W,
    parameter int WORD_W   = pe_pkg::WORD_W,
    parameter int DATA_W   = pe_pkg::DATA_W,
    parameter int FLAG_BIT = pe_pkg::FLAG_BIT
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              acc_start,
    input  logic              acc_end,
    input  logic              chk_valid,
    input  logic              chk_err,
    input  logic [MSG_W-1:0]  chk_msg,
    input  logic [WORD_W-1:0] chk_word,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data
);
    localparam int CODE_W = MSG_W + WORD_W;

    logic              any_rst_n;
    logic              commit;
    logic [MSG_W-1:0]  commit_msg;
    logic [WORD_W-1:0] commit_word;
    logic [MSG_W-1:0]  code_msg;
    logic [WORD_W-1:0] code_word;
    logic              flag_q;
    logic              stat_clr;
    logic [CODE_W-1:0] code_bits;

    // Either reset restarts access tracking and the flag.
    assign any_rst_n = por_n & rst_n;
    // A status read requests the flag clear.
    assign stat_clr  = rd_en & ~rd_sel;
    // Pack word number above message number.
    assign code_bits = {code_word, code_msg};

    pe_merge #(.MSG_W(MSG_W), .WORD_W(WORD_W)) u_merge (
        .clk        (clk),
        .rst_n      (any_rst_n),
        .acc_start  (acc_start),
        .acc_end    (acc_end),
        .chk_valid  (chk_valid),
        .chk_err    (chk_err),
        .chk_msg    (chk_msg),
        .chk_word   (chk_word),
        .commit     (commit),
        .commit_msg (commit_msg),
        .commit_word(commit_word)
    );

    pe_code_reg #(.MSG_W(MSG_W), .WORD_W(WORD_W)) u_code (
        .clk    (clk),
        .por_n  (por_n),
        .load   (commit),
        .msg_in (commit_msg),
        .word_in(commit_word),
        .msg_q  (code_msg),
        .word_q (code_word)
    );

    pe_flag u_flag (
        .clk   (clk),
        .rst_n (any_rst_n),
        .set   (commit),
        .clr   (stat_clr),
        .flag_q(flag_q)
    );

    // Select the status or code word, zero elsewhere.
    always_comb begin
        rd_data = '0;
        if (rd_sel) rd_data[CODE_W-1:0] = code_bits;
        else        rd_data[FLAG_BIT]   = flag_q;
    end
endmodule

// File: rtl/pe_chk.sv
// Protocol checker for the parity error recorder, bound to the top level.
module pe_chk #(
    parameter int MSG_W  = pe_pkg::MSG_W,
    parameter int WORD_W = pe_pkg::WORD_W,
    parameter int DATA_W = pe_pkg::DATA_W
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic              commit,
    input logic              stat_clr,
    input logic              flag_q,
    input logic [MSG_W-1:0]  code_msg,
    input logic [WORD_W-1:0] code_word,
    input logic              rd_sel,
    input logic [DATA_W-1:0] rd_data
);
    localparam int CODE_W = MSG_W + WORD_W;

    // R3: a commit raises the flag on the next cycle.
    p_flag_set_r3: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
        commit |=> flag_q);

    // R5: the flag holds without a status read.
    p_flag_hold_r5: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
        (flag_q && !stat_clr) |=> flag_q);

    // R5: a status read without a commit clears the flag.
    p_flag_clr_r5: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
        (stat_clr && !commit) |=> !flag_q);

    // R7: the held code never moves without a commit, soft reset included.
    p_code_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
        !commit |=> ($stable(code_msg) && $stable(code_word)));

    // R1: upper bits of the code word read zero.
    p_code_upper_r1: assert property (@(posedge clk) disable iff (!por_n)
        rd_sel |-> (rd_data[DATA_W-1:CODE_W] == '0));
endmodule

bind parity_err_recorder pe_chk #(.MSG_W(MSG_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .rst_n    (rst_n),
    .commit   (commit),
    .stat_clr (stat_clr),
    .flag_q   (flag_q),
    .code_msg (code_msg),
    .code_word(code_word),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data)
);

// File: tb/sim_parity_err_recorder.sv
`timescale 1ns/1ps
module sim_parity_err_recorder;
    logic        clk = 1'b0;
    logic        por_n, rst_n, acc_start, acc_end, chk_valid, chk_err, rd_en, rd_sel;
    logic [7:0]  chk_msg;
    logic [2:0]  chk_word;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference state
    bit       m_flag, m_in, m_aerr;
    bit [7:0] m_msg, m_amsg;
    bit [2:0] m_word, m_aword;

    always #2.5 clk = ~clk;

    parity_err_recorder u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .acc_start(acc_start), .acc_end(acc_end),
        .chk_valid(chk_valid), .chk_err(chk_err), .chk_msg(chk_msg), .chk_word(chk_word),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    function automatic bit [31:0] exp_read(bit sel);
        return sel ? {21'd0, m_word, m_msg} : {31'd0, m_flag};
    endfunction

    task automatic check(string tag, bit [31:0] act, bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance the reference state over one clock edge.
    task automatic model_step();
        bit act, berr, hit, take, nerr, cmt;
        bit [7:0] bmsg, nmsg;
        bit [2:0] bword, nword;
        if (!por_n) begin
            m_flag = 0; m_in = 0; m_aerr = 0; m_amsg = 0; m_aword = 0; m_msg = 0; m_word = 0;
        end else if (!rst_n) begin
            m_flag = 0; m_in = 0; m_aerr = 0; m_amsg = 0; m_aword = 0;
        end else begin
            act   = acc_start | m_in;
            berr  = acc_start ? 1'b0 : m_aerr;
            bmsg  = acc_start ? 8'd0 : m_amsg;
            bword = acc_start ? 3'd0 : m_aword;
            hit   = act & chk_valid & chk_err;
            take  = hit & (!berr || chk_word >= bword);
            nerr  = berr | hit;
            nmsg  = take ? chk_msg : bmsg;
            nword = take ? chk_word : bword;
            cmt   = acc_end & act & nerr;
            if (cmt) begin m_flag = 1; m_msg = nmsg; m_word = nword; end
            else if (rd_en && !rd_sel) m_flag = 0;
            if (acc_end) begin m_in = 0; m_aerr = 0; m_amsg = 0; m_aword = 0; end
            else begin m_in = act; m_aerr = nerr; m_amsg = nmsg; m_aword = nword; end
        end
    endtask

    // One cycle: drive at the falling edge, check the read, model the edge.
    task automatic cyc(bit p, bit r, bit s, bit e, bit v, bit er, bit [7:0] m, bit [2:0] w,
                       bit re, bit rs, string tag);
        @(negedge clk);
        por_n = p; rst_n = r; acc_start = s; acc_end = e; chk_valid = v; chk_err = er;
        chk_msg = m; chk_word = w; rd_en = re; rd_sel = rs;
        #1;
        if (p) check(tag, rd_data, exp_read(rs));
        model_step();
    endtask

    task automatic idle_read(bit sel, bit [31:0] lit, string tag);
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 0, sel, tag);
        check(tag, rd_data, lit);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        idle_read(1, 32'h0, "R8 code after power-on");
        idle_read(0, 32'h0, "R8 flag after power-on");

        // R4: several failing words, highest wins, tie goes to later check
        cyc(1, 1, 1, 0, 1, 1, 8'd5, 3'd2, 0, 0, "R4");
        cyc(1, 1, 0, 0, 1, 1, 8'd9, 3'd5, 0, 0, "R4");
        cyc(1, 1, 0, 0, 1, 1, 8'd7, 3'd3, 0, 0, "R4");
        cyc(1, 1, 0, 0, 1, 1, 8'd11, 3'd5, 0, 0, "R4");
        idle_read(0, 32'h0, "R3 no commit before end");
        cyc(1, 1, 0, 1, 1, 0, 8'd1, 3'd1, 0, 1, "R3");
        idle_read(1, 32'h50B, "R4 highest word kept");
        idle_read(0, 32'h1, "R3 flag set");
        // R11: code read keeps flag
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 1, 1, "R11");
        idle_read(0, 32'h1, "R11 flag after code read");
        // R5: status read clears
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 1, 0, "R5");
        idle_read(0, 32'h0, "R5 flag cleared");
        // R10: checks outside access ignored
        cyc(1, 1, 0, 0, 1, 1, 8'd99, 3'd4, 0, 0, "R10");
        cyc(1, 1, 0, 1, 1, 1, 8'd99, 3'd4, 0, 0, "R10");
        idle_read(1, 32'h50B, "R10 code untouched");
        idle_read(0, 32'h0, "R10 flag untouched");
        // R6: single-cycle access with error plus status read
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
        cyc(1, 1, 1, 1, 1, 1, 8'h80, 3'd1, 1, 0, "R6");
        idle_read(0, 32'h1, "R6 set wins over read");
        idle_read(1, 32'h180, "R9 overwrite by later access");
        // R9: clean access changes nothing
        cyc(1, 1, 1, 0, 1, 0, 8'd3, 3'd2, 0, 0, "R9");
        cyc(1, 1, 0, 1, 1, 0, 8'd3, 3'd3, 0, 0, "R9");
        idle_read(1, 32'h180, "R9 clean access keeps code");
        // R7: soft reset mid-access clears flag, keeps code, drops the access
        cyc(1, 1, 1, 0, 1, 1, 8'd20, 3'd5, 0, 0, "R7");
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
        cyc(1, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R7");
        idle_read(1, 32'h180, "R7 code survives soft reset");
        idle_read(0, 32'h0, "R7 flag cleared by soft reset");
        // R8: power-on reset clears code
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        idle_read(1, 32'h0, "R8 code cleared");

        // random traffic against the reference model
        for (int i = 0; i < 3000; i++) begin
            bit p, r, s, e, v, er, re, rs;
            p  = ($urandom_range(599, 0) != 0);
            r  = ($urandom_range(149, 0) != 0);
            s  = ($urandom_range(5, 0) == 0);
            e  = ($urandom_range(4, 0) == 0);
            v  = ($urandom_range(2, 0) != 0);
            er = ($urandom_range(3, 0) == 0);
            re = ($urandom_range(7, 0) == 0);
            rs = $urandom_range(1, 0);
            cyc(p, r, s, e, v, er, 8'($urandom_range(128, 1)), 3'($urandom_range(5, 1)),
                re, rs, rs ? "R1 R4 R9 random code" : "R2 R5 R6 random flag");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule